// File: doc/BRIEF.md
# Decimal Digit Adjust and Sign Extension Unit

This block is a small helper beside an integer datapath. It performs four operations on the accumulator register pair (a low word `AX`, split into a high byte and a low byte, and an extension word `DX`). Two operations work on unpacked decimal digits, which hold one decimal digit per byte. The first splits a binary byte into a tens digit and a units digit, for use after a multiply. The second merges a tens/units pair back into one binary byte, for use before a divide. The other two operations widen a signed value. One copies the sign of the low byte across the high byte. The other copies the sign of the word across the extension word.

The caller presents an operation code together with the current `AX` and `DX`, and raises `op_valid` for one cycle. On the following clock edge the unit registers the new register values. It also registers one write enable per destination and a flag write enable. Alongside these go sign, zero and parity flags for the two digit operations. The two widening operations change no flags. The division by ten uses a reciprocal multiply with a fixed constant, so there is no iterative divider, and the multiply by ten is built from two shifts and an add.

Top module: `dsx_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `ax_out`, `dx_out`, all write enables and all flag outputs are zero until the first accepted operation.
- R2: Operation code 0 (split): the new high byte is the old low byte divided by ten, and the new low byte is the old low byte modulo ten. The old high byte is ignored. This holds for all 256 low-byte values; for example 0x0048 becomes 0x0702 and 0x00FF becomes 0x1905.
- R3: Operation code 1 (merge): the new low byte is (old high byte times ten plus old low byte) modulo 256, and the new high byte is zero. For example 0x0702 becomes 0x0048 and 0xFF05 becomes 0x00FB.
- R4: Operation code 2 (byte widen): every bit of the new high byte equals bit 7 of the old low byte, and the low byte is unchanged. `ax_we` is 1 and `dx_we` is 0.
- R5: Operation code 3 (word widen): every bit of the new `dx_out` equals bit 15 of `ax_in`. `dx_we` is 1 and `ax_we` is 0. For example `ax_in` 0xFF81 gives 0xFFFF.
- R6: For codes 0 and 1, `flags_we` is 1. `sign_f` is bit 7 of the new low byte and `zero_f` is 1 when that byte is zero. `parity_f` is 1 when that byte has an even number of one bits.
- R7: For codes 2 and 3, `flags_we` is 0 and the flag outputs keep their previous values.
- R8: In a cycle with `op_valid` low, the next cycle shows all write enables at 0, with `ax_out` and `dx_out` unchanged.
- R9: Results and enables appear exactly one clock edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 2 | 0 split, 1 merge, 2 byte widen, 3 word widen |
| ax_in | input | 16 | Current accumulator word |
| dx_in | input | 16 | Current extension word |
| ax_out | output | 16 | New accumulator word |
| dx_out | output | 16 | New extension word |
| ax_we | output | 1 | Write `ax_out` back |
| dx_we | output | 1 | Write `dx_out` back |
| flags_we | output | 1 | Write the three flags back |
| sign_f | output | 1 | Sign of the new low byte |
| zero_f | output | 1 | New low byte is zero |
| parity_f | output | 1 | New low byte has even parity |

## Verification
The bench builds the unit with its default byte width of 8, so the full 256-value range of the low byte can be swept through the split operation. This makes every quotient and remainder of the reciprocal divide visible, including the top values where a constant that is too small would be off by one. The same width keeps the merge's modulo-256 wrap within reach of hand-picked high bytes such as 0xFF. It also lets both sign-bit polarities of each widening be tried with a handful of vectors.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

    typedef enum logic [1:0] {
        OP_SPLIT  = 2'd0,
        OP_MERGE  = 2'd1,
        OP_WIDEN_B = 2'd2,
        OP_WIDEN_W = 2'd3
    } dsx_op_e;

endpackage

// File: rtl/dsx_digit_split.sv
module dsx_digit_split #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int SH  = W + 4;
    localparam int PW  = 2 * W + 6;
    localparam logic [PW-1:0] MAG = PW'(((64'd1 << SH) + 64'd9) / 64'd10);

    logic [PW-1:0] prod;
    logic [PW-1:0] back;

    always_comb begin
        prod = PW'(val) * MAG;
        quo  = W'(prod >> SH);
        back = PW'(quo) * PW'(10);
        rem  = W'(PW'(val) - back);
    end

    // R2
    always_comb begin
        if (!$isunknown(val)) begin
            split_exact_chk: assert ((PW'(quo) * PW'(10) + PW'(rem)) == PW'(val) && rem < W'(10));
        end
    end

endmodule

// File: rtl/dsx_digit_merge.sv
module dsx_digit_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] tens,
    input  logic [W-1:0] units,
    output logic [W-1:0] merged
);
    logic [W-1:0] times8;
    logic [W-1:0] times2;

    always_comb begin
        times8 = tens << 3;
        times2 = tens << 1;
        merged = times8 + times2 + units;
    end

endmodule

// File: rtl/dsx_sign_fill.sv
module dsx_sign_fill #(
    parameter int W = 8
) (
    input  logic         msb,
    output logic [W-1:0] fill
);
    always_comb fill = {W{msb}};
endmodule

// File: rtl/dsx_unit.sv
module dsx_unit
    import dsx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_sel,
    input  logic [2*BYTE_W-1:0] ax_in,
    input  logic [2*BYTE_W-1:0] dx_in,
    output logic [2*BYTE_W-1:0] ax_out,
    output logic [2*BYTE_W-1:0] dx_out,
    output logic                ax_we,
    output logic                dx_we,
    output logic                flags_we,
    output logic                sign_f,
    output logic                zero_f,
    output logic                parity_f
);
    localparam int WW = 2 * BYTE_W;

    typedef struct packed {
        logic [WW-1:0] ax;
        logic [WW-1:0] dx;
        logic          ax_we;
        logic          dx_we;
        logic          flags_we;
        logic          sgn;
        logic          zf;
        logic          pf;
    } dsx_state_t;

    dsx_state_t st_d, st_q;

    logic [BYTE_W-1:0] lo_byte, hi_byte;
    logic [BYTE_W-1:0] split_quo, split_rem, merge_res;
    logic [BYTE_W-1:0] byte_fill;
    logic [WW-1:0]     word_fill;
    logic [BYTE_W-1:0] new_lo;
    dsx_op_e           op;

    assign lo_byte = ax_in[BYTE_W-1:0];
    assign hi_byte = ax_in[WW-1:BYTE_W];
    assign op      = dsx_op_e'(op_sel);

    dsx_digit_split #(.W(BYTE_W)) u_split (
        .val (lo_byte),
        .quo (split_quo),
        .rem (split_rem)
    );

    dsx_digit_merge #(.W(BYTE_W)) u_merge (
        .tens   (hi_byte),
        .units  (lo_byte),
        .merged (merge_res)
    );

    dsx_sign_fill #(.W(BYTE_W)) u_fill_b (
        .msb  (lo_byte[BYTE_W-1]),
        .fill (byte_fill)
    );

    dsx_sign_fill #(.W(WW)) u_fill_w (
        .msb  (ax_in[WW-1]),
        .fill (word_fill)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ax_we    = 1'b0;
        st_d.dx_we    = 1'b0;
        st_d.flags_we = 1'b0;
        new_lo        = '0;
        if (op_valid) begin
            case (op)
                OP_SPLIT: begin
                    new_lo        = split_rem;
                    st_d.ax       = {split_quo, split_rem};
                    st_d.ax_we    = 1'b1;
                    st_d.flags_we = 1'b1;
                end
                OP_MERGE: begin
                    new_lo        = merge_res;
                    st_d.ax       = {{BYTE_W{1'b0}}, merge_res};
                    st_d.ax_we    = 1'b1;
                    st_d.flags_we = 1'b1;
                end
                OP_WIDEN_B: begin
                    st_d.ax    = {byte_fill, lo_byte};
                    st_d.ax_we = 1'b1;
                end
                default: begin
                    st_d.dx    = word_fill;
                    st_d.dx_we = 1'b1;
                end
            endcase
            if (st_d.flags_we) begin
                st_d.sgn = new_lo[BYTE_W-1];
                st_d.zf  = (new_lo == '0);
                st_d.pf  = ~^new_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ax_out   = st_q.ax;
    assign dx_out   = st_q.dx;
    assign ax_we    = st_q.ax_we;
    assign dx_we    = st_q.dx_we;
    assign flags_we = st_q.flags_we;
    assign sign_f   = st_q.sgn;
    assign zero_f   = st_q.zf;
    assign parity_f = st_q.pf;

    // R9
    ax_we_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel != 2'd3) |=> (ax_we && !dx_we));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!ax_we && !dx_we && !flags_we && $stable(ax_out) && $stable(dx_out)));

    // R7
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |-> $stable({sign_f, zero_f, parity_f}));

    // R3
    merge_clear_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd1) |=> (ax_out[WW-1:BYTE_W] == '0));

    // R5
    word_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd3) |=> (dx_out == {WW{$past(ax_in[WW-1])}} && !ax_we));

endmodule

// File: tb/dsx_unit_bench.sv
module dsx_unit_bench;

    localparam int NV = 10;

    localparam logic [1:0]  V_OP  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd3, 2'd1, 2'd1, 2'd0, 2'd1};
    localparam logic [15:0] V_AX  [NV] = '{16'h0048, 16'h0702, 16'h0081, 16'hFF81, 16'h127F,
                                           16'h7FFF, 16'h0909, 16'hFF05, 16'h00FF, 16'h0000};
    localparam logic [15:0] V_DX  [NV] = '{16'h1111, 16'h2222, 16'h3333, 16'h1234, 16'h5555,
                                           16'hABCD, 16'h6666, 16'h7777, 16'h8888, 16'h9999};
    localparam logic [15:0] V_EAX [NV] = '{16'h0702, 16'h0048, 16'hFF81, 16'h0000, 16'h007F,
                                           16'h0000, 16'h0063, 16'h00FB, 16'h1905, 16'h0000};
    localparam logic [15:0] V_EDX [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000,
                                           16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [15:0] ax_in = '0;
    logic [15:0] dx_in = '0;
    logic [15:0] ax_out, dx_out;
    logic        ax_we, dx_we, flags_we, sign_f, zero_f, parity_f;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsx_unit u_dsx_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .ax_in(ax_in), .dx_in(dx_in), .ax_out(ax_out), .dx_out(dx_out),
        .ax_we(ax_we), .dx_we(dx_we), .flags_we(flags_we),
        .sign_f(sign_f), .zero_f(zero_f), .parity_f(parity_f)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] ax, input logic [15:0] dx);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        ax_in    = ax;
        dx_in    = dx;
        @(posedge clk);
        #1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic logic [2:0] ref_flags(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += b[i];
        return {b[7], b == 8'h00, (ones % 2) == 0};
    endfunction

    initial begin
        logic [15:0] prev_ax, prev_dx;
        logic [2:0]  prev_fl;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 ax", ax_out, 0);
        chk("R1 dx", dx_out, 0);
        chk("R1 we", {ax_we, dx_we, flags_we, sign_f, zero_f, parity_f}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", {ax_out, dx_out, ax_we, dx_we, flags_we}, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            prev_ax = ax_out;
            prev_dx = dx_out;
            prev_fl = {sign_f, zero_f, parity_f};
            issue(V_OP[v], V_AX[v], V_DX[v]);
            // sampled one edge after issue (R9); now at negedge, outputs stable
            case (V_OP[v])
                2'd0, 2'd1: begin
                    chk(V_OP[v] == 0 ? "R2 split ax" : "R3 merge ax", ax_out, V_EAX[v]);
                    chk("R9 we", {ax_we, dx_we, flags_we}, 3'b101);
                    chk("R6 flags", {sign_f, zero_f, parity_f}, ref_flags(V_EAX[v][7:0]));
                    chk("R6 dx kept", dx_out, prev_dx);
                end
                2'd2: begin
                    chk("R4 widen byte", ax_out, V_EAX[v]);
                    chk("R4 we", {ax_we, dx_we, flags_we}, 3'b100);
                    chk("R7 flags kept", {sign_f, zero_f, parity_f}, prev_fl);
                end
                default: begin
                    chk("R5 widen word", dx_out, V_EDX[v]);
                    chk("R5 we", {ax_we, dx_we, flags_we}, 3'b010);
                    chk("R5 ax kept", ax_out, prev_ax);
                    chk("R7 flags kept", {sign_f, zero_f, parity_f}, prev_fl);
                end
            endcase
        end

        // R2 exhaustive split over all low-byte values, high byte garbage
        for (int a = 0; a < 256; a++) begin
            logic [7:0] q, r;
            q = 8'(a / 10);
            r = 8'(a % 10);
            issue(2'd0, {8'(255 - a), 8'(a)}, 16'h0);
            chk("R2 split sweep", ax_out, {q, r});
        end

        // R8 idle hold
        issue(2'd3, 16'h8000, 16'h0);
        @(posedge clk);
        #1;
        prev_ax = ax_out;
        prev_dx = dx_out;
        ax_in = 16'h1234;
        op_sel = 2'd1;
        @(posedge clk);
        #1;
        chk("R8 idle we", {ax_we, dx_we, flags_we}, 3'b000);
        chk("R8 idle ax", ax_out, prev_ax);
        chk("R8 idle dx", dx_out, 16'hFFFF);

        // R9 latency: result must not be visible before the edge
        @(negedge clk);
        op_valid = 1'b1;
        op_sel = 2'd2;
        ax_in = 16'h0080;
        #2;
        chk("R9 no early update", {ax_we, ax_out}, {1'b0, prev_ax});
        @(posedge clk);
        #1;
        chk("R9 updated", {ax_we, ax_out}, {1'b1, 16'hFF80});
        @(negedge clk);
        op_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule